// File: doc/BRIEF.md
# Error-feedback sigma-delta rounder

This block shortens a signed fixed-point sample stream from `W_IN` bits to `W_OUT` bits, one sample per clock. It does not round each sample on its own. The part of a sample lost to rounding is carried forward and added to the next input before that input is quantized. The error is therefore spread out as shaped noise and does not build up as a steady bias. A held input thus produces output codes whose mean, scaled back up, equals the input value. A common setting takes 24-bit filter results down to 18 bits.

The loop sum is held in a register. A rounding quantizer reads that register. The quantizer's leftover error is sign-extended and added to the next input by an adder that saturates at the signed `W_IN` limits and never wraps. The output is taken straight from the quantizer of the registered sum, so every input reaches the output one clock after it is applied.

Top module: `sdr_round_sd`

## Requirements
- R1: While `rst_n` is low at a rising edge, the loop register is cleared to zero. From the next edge on, `dout` reads 0 until the first edge after release. After release the block behaves as if no error had been stored before.
- R2: An input applied before rising edge k shows its effect on `dout` directly after edge k. From a cleared state, the first input x gives `dout` = round(x / 2^(W_IN-W_OUT)).
- R3: The quantizer rounds half away from zero. With shift S = W_IN-W_OUT = 6, input 32 gives 1, -32 gives -1, 31 gives 0 and -31 gives 0. The error equals the loop value minus `dout`·2^S and lies in [-2^(S-1), 2^(S-1)] whenever the output is not saturated.
- R4: When rounding would exceed the largest positive `W_OUT` code, `dout` saturates to 2^(W_OUT-1)-1, which is 131071 for the defaults. An input of 2^(W_IN-1)-1 from a cleared state gives that code.
- R5: The sum of the input and the fed-back error is clipped to [-2^(W_IN-1), 2^(W_IN-1)-1] and never wraps. A full-scale positive input held for many clocks keeps `dout` at 131071, and a full-scale negative input keeps it at -131072.
- R6: Each clock the loop register loads clip(input + sign-extended error of the current loop value). For example, a held input of 16 after reset gives the output sequence 0, 1, 0, 0, 0, 1, 0, 0, ...
- R7: For a constant input x away from full scale, the sum of `dout` over 2^S consecutive samples, times 2^S, differs from 2^S·x by at most 2^S. That is, the average is within one input LSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | W_IN | Signed wide input sample, one per clock |
| dout | output | W_OUT | Signed rounded output sample |

## Verification
The in-line assertions check four things on every cycle. The rounding error stays within half an output step unless the output is saturated. The top code appears only when the loop value is within half a step of the ceiling. A loop sum built from two terms of the same sign keeps that sign, so the adder never wraps. The output reads zero on the first cycle after reset. Only the bench's scenarios can show what the exact output sequence is for a held input, that the halfway cases round away from zero, the one-clock latency, that reset wipes the stored error, and that the average over 64 samples matches the input.

// File: rtl/sdr_rnd_pkg.sv
// Shared types for the sigma-delta rounder.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sdr_rnd_pkg;
    // Outcome of a saturating add.
    typedef enum logic [1:0] {
        CLIP_NONE = 2'd0,
        CLIP_POS  = 2'd1,
        CLIP_NEG  = 2'd2
    } clip_kind_e;
endpackage

// File: rtl/sdr_rnd_quant.sv
// Rounding quantizer: maps a signed W_IN value to W_OUT bits, rounding half
// away from zero and saturating at the top positive code. Also returns the
// signed residual (value minus rounded value scaled back up), SH+1 bits wide.
// Assumes W_IN > W_OUT >= 2. Purely combinational.
module sdr_rnd_quant #(
    parameter int W_IN  = 24,
    parameter int W_OUT = 18
) (
    input  logic signed [W_IN-1:0]        val_i,
    output logic signed [W_OUT-1:0]       q_o,
    output logic signed [W_IN-W_OUT:0]    err_o
);
    localparam int SH   = W_IN - W_OUT;
    localparam int HALF = 1 << (SH - 1);
    localparam logic [W_IN:0] BIAS_P = (W_IN+1)'(HALF);
    localparam logic [W_IN:0] BIAS_N = (W_IN+1)'(HALF - 1);
    localparam logic [W_OUT-1:0] Q_MAX = {1'b0, {(W_OUT-1){1'b1}}};

    logic [W_IN:0]    biased;
    logic [W_OUT:0]   rnd;
    logic [SH-1:0]    frac_unused;
    logic             ovf;

    // Add the half-step bias; negatives use one less so halves go downward.
    always_comb begin
        biased = {val_i[W_IN-1], val_i} + (val_i[W_IN-1] ? BIAS_N : BIAS_P);
    end

    // Floor-divide by 2^SH by dropping the fraction bits.
    assign {rnd, frac_unused} = biased;

    // Only a positive value can spill past W_OUT bits.
    assign ovf = rnd[W_OUT] ^ rnd[W_OUT-1];

    // Select the saturated or plain rounded code.
    always_comb begin
        q_o = ovf ? Q_MAX : rnd[W_OUT-1:0];
    end

    // Residual fits in SH+1 bits, so modular low-bit subtraction is exact.
    always_comb begin
        err_o = val_i[SH:0] - {q_o[0], {SH{1'b0}}};
    end
endmodule

// File: rtl/sdr_sat_add.sv
// Saturating signed adder: sums two W-bit signed values and clamps the result
// to the signed W-bit range instead of wrapping. Combinational.
// Assumes W >= 2.
module sdr_sat_add
    import sdr_rnd_pkg::*;
#(
    parameter int W = 24
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic signed [W-1:0] sum_o
);
    localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]  wide;
    clip_kind_e  kind;

    // Full-precision sum with one guard bit.
    always_comb begin
        wide = {a_i[W-1], a_i} + {b_i[W-1], b_i};
    end

    // Classify overflow from the guard and top bits.
    always_comb begin
        if (wide[W] == wide[W-1]) kind = CLIP_NONE;
        else if (wide[W])         kind = CLIP_NEG;
        else                      kind = CLIP_POS;
    end

    // Drive the clamped or plain result.
    always_comb begin
        case (kind)
            CLIP_POS: sum_o = S_MAX;
            CLIP_NEG: sum_o = S_MIN;
            default:  sum_o = wide[W-1:0];
        endcase
    end
endmodule

// File: rtl/sdr_round_sd.sv
// Error-feedback sigma-delta rounder, top level. Each clock the loop register
// loads clip(din + sign-extended residual of the current loop value), and
// dout is the rounded loop value. Latency is one clock.
// Assumes W_IN > W_OUT >= 2, one sample per clock, synchronous active-low reset.
module sdr_round_sd #(
    parameter int W_IN  = 24,
    parameter int W_OUT = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [W_IN-1:0]  din,
    output logic signed [W_OUT-1:0] dout
);
    localparam int SH   = W_IN - W_OUT;
    localparam int E_W  = SH + 1;
    localparam int HALF = 1 << (SH - 1);
    localparam logic signed [W_OUT-1:0] Q_MAX = {1'b0, {(W_OUT-1){1'b1}}};
    localparam longint SAT_EDGE = (longint'(Q_MAX) <<< SH) - longint'(HALF);

    logic signed [W_IN-1:0] loop_q;
    logic signed [W_IN-1:0] loop_d;
    logic signed [E_W-1:0]  err;
    logic signed [W_IN-1:0] err_ext;

    sdr_rnd_quant #(.W_IN(W_IN), .W_OUT(W_OUT)) u_quant (
        .val_i (loop_q),
        .q_o   (dout),
        .err_o (err)
    );

    // Sign-extend the residual to the loop width.
    assign err_ext = {{(W_IN-E_W){err[E_W-1]}}, err};

    sdr_sat_add #(.W(W_IN)) u_add (
        .a_i   (din),
        .b_i   (err_ext),
        .sum_o (loop_d)
    );

    // Loop register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) loop_q <= '0;
        else        loop_q <= loop_d;
    end

    // R3: residual within half a step when not saturated
    p_err_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != Q_MAX) |-> (int'(err) >= -HALF && int'(err) <= HALF));

    // R4: top code only near the ceiling
    p_sat_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dout == Q_MAX) |-> (longint'(loop_q) >= SAT_EDGE));

    // R5: loop sum keeps the sign of two same-sign terms
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !din[W_IN-1] && !err[E_W-1]) |=> !loop_q[W_IN-1]);

    p_no_wrap_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rst_n && din[W_IN-1] && err[E_W-1]) |=> loop_q[W_IN-1]);

    // R1: output is zero right after reset release
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dout == '0));
endmodule

// File: tb/tb_sdr_round_sd.sv
`timescale 1ns/1ps
// Directed bench for sdr_round_sd with an arithmetic model from the requirements.
module tb_sdr_round_sd;
    localparam int W_IN  = 24;
    localparam int W_OUT = 18;
    localparam int SH    = W_IN - W_OUT;
    localparam longint SCALE = 64;
    localparam longint HALF  = 32;
    localparam longint OMAX  = (longint'(1) << (W_OUT-1)) - 1;
    localparam longint IMAX  = (longint'(1) << (W_IN-1)) - 1;
    localparam longint IMIN  = -(longint'(1) << (W_IN-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [W_IN-1:0]  din = '0;
    logic signed [W_OUT-1:0] dout;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    longint m_acc = 0;

    sdr_round_sd #(.W_IN(W_IN), .W_OUT(W_OUT)) dut (
        .clk(clk), .rst_n(rst_n), .din(din), .dout(dout)
    );

    always #2.5 clk = ~clk;

    function automatic longint m_quant(longint a);
        longint r;
        r = (a >= 0) ? ((a + HALF) >>> SH) : ((a + HALF - 1) >>> SH);
        if (r > OMAX) r = OMAX;
        return r;
    endfunction

    function automatic longint m_clip(longint x);
        if (x > IMAX) return IMAX;
        if (x < IMIN) return IMIN;
        return x;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint rd();
        return longint'(dout);
    endfunction

    // One sample through model and DUT; returns the sampled output.
    task automatic step(longint v, string req, output longint got);
        longint e;
        @(negedge clk);
        din = v[W_IN-1:0];
        e = m_acc - m_quant(m_acc) * SCALE;
        m_acc = m_clip(v + e);
        @(posedge clk);
        #1;
        got = rd();
        chk(req, got, m_quant(m_acc));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        din = 24'h3A5A5A;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk("R1 reset output", rd(), 0);
        m_acc = 0;
        @(negedge clk);
        rst_n = 1'b1;
        din = '0;
    endtask

    task automatic t_latency();
        longint g;
        do_reset();
        step(1000, "R2 first sample", g);
        chk("R2 round(1000/64)", g, 16);
    endtask

    task automatic t_rounding();
        longint g;
        do_reset(); step(32, "R3 +half", g);  chk("R3 +half away", g, 1);
        do_reset(); step(-32, "R3 -half", g); chk("R3 -half away", g, -1);
        do_reset(); step(31, "R3 +31", g);    chk("R3 below half", g, 0);
        do_reset(); step(-31, "R3 -31", g);   chk("R3 above -half", g, 0);
    endtask

    task automatic t_sat();
        longint g;
        do_reset();
        step(IMAX, "R4 full scale", g);
        chk("R4 saturated code", g, OMAX);
    endtask

    task automatic t_clip();
        longint g;
        do_reset();
        for (int i = 0; i < 20; i++) begin
            step(IMAX, "R5 held +full", g);
            chk("R5 no wrap +", g, OMAX);
        end
        do_reset();
        for (int i = 0; i < 20; i++) begin
            step(IMIN, "R5 held -full", g);
            chk("R5 no wrap -", g, -(OMAX + 1));
        end
    endtask

    task automatic t_feedback();
        longint g;
        longint exp_seq[8] = '{0, 1, 0, 0, 0, 1, 0, 0};
        do_reset();
        for (int i = 0; i < 8; i++) begin
            step(16, "R6 model", g);
            chk("R6 sequence", g, exp_seq[i]);
        end
        for (int i = 0; i < 10; i++) step(-777 * i + 5000, "R6 ramp", g);
        do_reset();
        step(16, "R1 cleared state", g);
        chk("R1 no stale error", g, 0);
    endtask

    task automatic t_average(longint x);
        longint g;
        longint s;
        longint d;
        do_reset();
        for (int i = 0; i < 4; i++) step(x, "R7 warm", g);
        s = 0;
        for (int i = 0; i < 64; i++) begin
            step(x, "R7 model", g);
            s += g;
        end
        d = s * SCALE - SCALE * x;
        if (d < 0) d = -d;
        chk("R7 average within 1 LSB", (d <= SCALE) ? 1 : 0, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R1 output during reset", rd(), 0);
        t_latency();
        t_rounding();
        t_sat();
        t_clip();
        t_feedback();
        t_average(16);
        t_average(-16);
        t_average(1000);
        t_average(-12345);
        t_average(37);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule